// File: doc/BRIEF.md
# Bus Address Breakpoint Comparator

This block sits beside a processor bus as a passive observer. Every time the bus presents an address with its valid strobe, the block decides whether that access hits a single programmed breakpoint. The decision looks at the transfer direction, the address, and the transfer size. The result is a one-cycle breakpoint pulse that debug or trap logic further down the chip consumes.

There are two ways to judge size. In exact mode, the access must start at the programmed address and have the programmed size. In masked mode, the access size is not compared. Instead, the block checks whether any byte the access touches is the programmed byte, which suits catching instruction fetches that begin below the target.

In a burst, only the first beat is judged. Configuration arrives as plain level inputs held by a register file elsewhere. The bus side is observe-only: it has no ready signal and applies no back-pressure, and the block never stalls or alters a transfer.

Top module: `bus_break_unit`

## Requirements
- R1: The direction select picks which accesses can match: 00 matches reads only, 01 matches writes only, and 10 matches both. A read is `bus_rnw`=1 and a write is `bus_rnw`=0.
- R2: With direction select 11, no access ever produces a breakpoint, whatever the other inputs are.
- R3: With the size mask at 0, a match needs `bus_addr` equal to `cfg_addr` and the access size equal to `cfg_size`. Sizes are encoded as 00 = byte (1 byte), 01 = word (2 bytes) and 10 = long word (4 bytes). Code 11 counts as long word, so 11 and 10 compare as equal.
- R4: With the size mask at 1, size is not compared. A match occurs when `bus_addr` ≤ `cfg_addr` < `bus_addr` + byte count. For example, with the target at offset 2, a word at offset 2 matches and a long word at offset 0 matches.
- R5: The range computation of R4 does not wrap past the top of the address space. A long word at 0xFFFFFFFE does not cover address 0.
- R6: A strobe with `bus_burst_start`=1 opens a burst of BURST_BEATS beats (default 4) and is itself compared. The following BURST_BEATS-1 strobes never match. A new `bus_burst_start` restarts the count, and that strobe is compared.
- R7: `brk_pulse` is registered. It is high for exactly the one cycle after a matching strobe, and it is low after any cycle without a strobe.
- R8: While `cfg_en` is 0, `brk_pulse` stays low.
- R9: Reset is synchronous and active-low. It forces `brk_pulse` low and ends any open burst.
- R10: Configuration inputs may change at any time. Each strobe is judged against the configuration present in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Global breakpoint enable |
| cfg_rw | input | 2 | Direction select (00 read, 01 write, 10 both, 11 reserved) |
| cfg_size_mask | input | 1 | 1 = range overlap match, 0 = exact size match |
| cfg_size | input | 2 | Programmed transfer size |
| cfg_addr | input | 32 | Programmed breakpoint byte address |
| bus_addr | input | 32 | Access start address |
| bus_size | input | 2 | Access transfer size |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_as | input | 1 | Address-valid strobe, one per beat |
| bus_burst_start | input | 1 | Marks the first beat of a burst |
| brk_pulse | output | 1 | Registered one-cycle breakpoint pulse |

## Verification
The only result is `brk_pulse`, and it falls due exactly one rising edge after the strobe cycle that caused it. The bench drives each strobe just after a falling edge and holds it for one cycle. It then samples `brk_pulse` at the next falling edge, which lands mid-way through the cycle that follows the capturing edge. Checks of the pulse's width and of burst beat counting use the same fixed one-cycle offset for each later strobe or idle cycle. Reset is checked one edge after it is applied.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  typedef enum logic [1:0] {
    DIR_READ  = 2'b00,
    DIR_WRITE = 2'b01,
    DIR_ANY   = 2'b10,
    DIR_RSVD  = 2'b11
  } dir_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_XL   = 2'b11
  } xfer_sz_e;

  // byte count covered by a transfer-size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (xfer_sz_e'(sz))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bbu_dir_filter.sv
module bbu_dir_filter
  import bbu_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       rnw,
  output logic       pass
);

  always_comb begin
    case (dir_sel_e'(sel))
      DIR_READ:  pass = rnw;
      DIR_WRITE: pass = ~rnw;
      DIR_ANY:   pass = 1'b1;
      default:   pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/bbu_range_match.sv
module bbu_range_match
  import bbu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] tgt_addr,
  input  logic [1:0]    tgt_size,
  input  logic          size_mask,
  output logic          hit
);

  localparam int EW = AW + 1;

  logic [2:0]    acc_bytes;
  logic [EW-1:0] acc_lo;
  logic [EW-1:0] acc_hi;
  logic [EW-1:0] tgt_ext;
  logic          exact_hit;
  logic          span_hit;

  always_comb begin
    acc_bytes = size_bytes(acc_size);
    acc_lo    = {1'b0, acc_addr};
    // one extra bit keeps the end of the span from wrapping to zero
    acc_hi    = acc_lo + EW'(acc_bytes);
    tgt_ext   = {1'b0, tgt_addr};
    exact_hit = (acc_addr == tgt_addr) && (acc_bytes == size_bytes(tgt_size));
    span_hit  = (acc_lo <= tgt_ext) && (tgt_ext < acc_hi);
    hit       = size_mask ? span_hit : exact_hit;
  end

endmodule

// File: rtl/bbu_burst_track.sv
module bbu_burst_track #(
  parameter int BURST_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic first,
  output logic later_beat
);

  localparam int CW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(BURST_BEATS - 1);

  logic [CW-1:0] beats_left;

  assign later_beat = (beats_left != '0) && !first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats_left <= '0;
    end else if (strobe) begin
      if (first) begin
        beats_left <= RELOAD;
      end else if (beats_left != '0) begin
        beats_left <= beats_left - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BURST_BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_rw,
  input  logic          cfg_size_mask,
  input  logic [1:0]    cfg_size,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic          bus_rnw,
  input  logic          bus_as,
  input  logic          bus_burst_start,
  output logic          brk_pulse
);

  logic dir_ok;
  logic addr_ok;
  logic later_beat;
  logic hit_now;

  bbu_dir_filter u_dir (
    .sel  (cfg_rw),
    .rnw  (bus_rnw),
    .pass (dir_ok)
  );

  bbu_range_match #(.AW(AW)) u_rng (
    .acc_addr  (bus_addr),
    .acc_size  (bus_size),
    .tgt_addr  (cfg_addr),
    .tgt_size  (cfg_size),
    .size_mask (cfg_size_mask),
    .hit       (addr_ok)
  );

  bbu_burst_track #(.BURST_BEATS(BURST_BEATS)) u_bst (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (bus_as),
    .first      (bus_burst_start),
    .later_beat (later_beat)
  );

  assign hit_now = bus_as && cfg_en && dir_ok && addr_ok && !later_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) brk_pulse <= 1'b0;
    else        brk_pulse <= hit_now;
  end

endmodule

// File: rtl/bbu_checker.sv
module bbu_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic [1:0]    cfg_rw,
  input logic          cfg_size_mask,
  input logic [1:0]    cfg_size,
  input logic [AW-1:0] cfg_addr,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic          bus_rnw,
  input logic          bus_as,
  input logic          later_beat,
  input logic          brk_pulse
);

  AST_RSVD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && cfg_rw == 2'b11) |=> !brk_pulse); // R2

  AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && cfg_rw == 2'b00 && !bus_rnw) |=> !brk_pulse); // R1

  AST_EXACT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && !cfg_size_mask && (bus_size[1] != cfg_size[1] ||
     (!bus_size[1] && bus_size[0] != cfg_size[0]))) |=> !brk_pulse); // R3

  AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && cfg_en && cfg_rw == 2'b10 && !cfg_size_mask && !later_beat &&
     bus_addr == cfg_addr && bus_size == cfg_size) |=> brk_pulse); // R3

  AST_MASK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && cfg_en && cfg_rw == 2'b10 && cfg_size_mask && !later_beat &&
     bus_addr == cfg_addr) |=> brk_pulse); // R4

  AST_LATER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && later_beat) |=> !brk_pulse); // R6

  AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as |=> !brk_pulse); // R7

  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !brk_pulse); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !brk_pulse); // R9

endmodule

bind bus_break_unit bbu_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .cfg_rw        (cfg_rw),
  .cfg_size_mask (cfg_size_mask),
  .cfg_size      (cfg_size),
  .cfg_addr      (cfg_addr),
  .bus_addr      (bus_addr),
  .bus_size      (bus_size),
  .bus_rnw       (bus_rnw),
  .bus_as        (bus_as),
  .later_beat    (later_beat),
  .brk_pulse     (brk_pulse)
);

// File: tb/bus_break_unit_bench.sv
`timescale 1ns/1ps
module bus_break_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en;
  logic [1:0]  cfg_rw;
  logic        cfg_size_mask;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_addr;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rnw;
  logic        bus_as;
  logic        bus_burst_start;
  logic        brk_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bus_break_unit u_bus_break_unit (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rw(cfg_rw),
    .cfg_size_mask(cfg_size_mask), .cfg_size(cfg_size), .cfg_addr(cfg_addr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_rnw(bus_rnw),
    .bus_as(bus_as), .bus_burst_start(bus_burst_start), .brk_pulse(brk_pulse)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        en;
    logic [1:0]  rw;
    logic        sm;
    logic [1:0]  cs;
    logic [31:0] ca;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        rnw;
    logic        exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b1, 2'b00, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b1, 1'b1}, // R1 read sel, read
    '{4'd1, 1'b1, 2'b00, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b0, 1'b0}, // R1 read sel, write
    '{4'd1, 1'b1, 2'b01, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b0, 1'b1}, // R1 write sel, write
    '{4'd1, 1'b1, 2'b10, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b0, 1'b1}, // R1 both, write
    '{4'd1, 1'b1, 2'b10, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b1, 1'b1}, // R1 both, read
    '{4'd2, 1'b1, 2'b11, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b1, 1'b0}, // R2 reserved, read
    '{4'd2, 1'b1, 2'b11, 1'b1, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b0, 1'b0}, // R2 reserved, masked
    '{4'd3, 1'b1, 2'b10, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b10, 1'b1, 1'b0}, // R3 size differs
    '{4'd3, 1'b1, 2'b10, 1'b0, 2'b10, 32'h1000, 32'h1000, 2'b11, 1'b1, 1'b1}, // R3 11 equals 10
    '{4'd3, 1'b1, 2'b10, 1'b0, 2'b01, 32'h1000, 32'h1002, 2'b01, 1'b1, 1'b0}, // R3 address differs
    '{4'd4, 1'b1, 2'b10, 1'b1, 2'b00, 32'h1002, 32'h1002, 2'b01, 1'b1, 1'b1}, // R4 word at 2
    '{4'd4, 1'b1, 2'b10, 1'b1, 2'b00, 32'h1002, 32'h1000, 2'b10, 1'b1, 1'b1}, // R4 long at 0
    '{4'd4, 1'b1, 2'b10, 1'b1, 2'b00, 32'h1002, 32'h1000, 2'b01, 1'b1, 1'b0}, // R4 word at 0 misses
    '{4'd4, 1'b1, 2'b10, 1'b1, 2'b00, 32'h1002, 32'h1001, 2'b01, 1'b1, 1'b1}, // R4 word at 1
    '{4'd4, 1'b1, 2'b10, 1'b1, 2'b00, 32'h1003, 32'h1000, 2'b11, 1'b1, 1'b1}, // R4 code 11 spans 4
    '{4'd4, 1'b1, 2'b10, 1'b1, 2'b00, 32'h1004, 32'h1000, 2'b10, 1'b1, 1'b0}, // R4 one past end
    '{4'd5, 1'b1, 2'b10, 1'b1, 2'b00, 32'h0,    32'hFFFFFFFE, 2'b10, 1'b1, 1'b0}, // R5 no wrap
    '{4'd5, 1'b1, 2'b10, 1'b1, 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFE, 2'b01, 1'b1, 1'b1}, // R5 top byte
    '{4'd8, 1'b0, 2'b10, 1'b0, 2'b01, 32'h1000, 32'h1000, 2'b01, 1'b1, 1'b0}  // R8 disabled
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: brk_pulse actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic en, input logic [1:0] rw, input logic sm,
                         input logic [1:0] cs, input logic [31:0] ca);
    cfg_en = en; cfg_rw = rw; cfg_size_mask = sm; cfg_size = cs; cfg_addr = ca;
  endtask

  // strobe in the current cycle; returns at the next falling edge
  task automatic strobe(input logic [31:0] a, input logic [1:0] s,
                        input logic rnw, input logic first);
    bus_addr = a; bus_size = s; bus_rnw = rnw; bus_burst_start = first;
    bus_as = 1'b1;
    @(negedge clk);
    bus_as = 1'b0; bus_burst_start = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7: watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    set_cfg(1'b0, 2'b00, 1'b0, 2'b00, 32'h0);
    bus_addr = '0; bus_size = '0; bus_rnw = 1'b0; bus_as = 1'b0; bus_burst_start = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset state", brk_pulse, 1'b0);
    rst_n = 1'b1;
    idle();

    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i].en, VEC[i].rw, VEC[i].sm, VEC[i].cs, VEC[i].ca);
      strobe(VEC[i].addr, VEC[i].sz, VEC[i].rnw, 1'b0);
      check($sformatf("R%0d vector %0d", VEC[i].tag, i), brk_pulse, VEC[i].exp);
      idle();
      check("R7 pulse ends", brk_pulse, 1'b0);
    end

    // R7: matching inputs without a strobe
    set_cfg(1'b1, 2'b10, 1'b0, 2'b01, 32'h1000);
    bus_addr = 32'h1000; bus_size = 2'b01; bus_rnw = 1'b1;
    idle();
    check("R7 no strobe", brk_pulse, 1'b0);

    // R7: back-to-back matching strobes give one pulse each
    strobe(32'h1000, 2'b01, 1'b1, 1'b0);
    check("R7 first of pair", brk_pulse, 1'b1);
    strobe(32'h1000, 2'b01, 1'b1, 1'b0);
    check("R7 second of pair", brk_pulse, 1'b1);
    idle();
    check("R7 after pair", brk_pulse, 1'b0);

    // R6: burst with first beat compared, later beats ignored
    set_cfg(1'b1, 2'b10, 1'b1, 2'b00, 32'h2000);
    strobe(32'h2000, 2'b10, 1'b1, 1'b1);
    check("R6 first beat", brk_pulse, 1'b1);
    for (int b = 0; b < 3; b++) begin
      strobe(32'h2000, 2'b10, 1'b1, 1'b0);
      check("R6 later beat", brk_pulse, 1'b0);
    end
    strobe(32'h2000, 2'b10, 1'b1, 1'b0);
    check("R6 after burst", brk_pulse, 1'b1);

    // R6: a new start during a burst is compared and restarts the count
    strobe(32'h2000, 2'b10, 1'b1, 1'b1);
    check("R6 start A", brk_pulse, 1'b1);
    strobe(32'h2000, 2'b10, 1'b1, 1'b0);
    check("R6 beat A2", brk_pulse, 1'b0);
    strobe(32'h2000, 2'b10, 1'b1, 1'b1);
    check("R6 restart", brk_pulse, 1'b1);
    for (int b = 0; b < 3; b++) begin
      strobe(32'h2000, 2'b10, 1'b1, 1'b0);
      check("R6 beat after restart", brk_pulse, 1'b0);
    end

    // R9: reset in mid-burst closes the burst
    strobe(32'h2000, 2'b10, 1'b1, 1'b1);
    check("R6 start B", brk_pulse, 1'b1);
    rst_n = 1'b0;
    idle();
    check("R9 reset clears", brk_pulse, 1'b0);
    rst_n = 1'b1;
    strobe(32'h2000, 2'b10, 1'b1, 1'b0);
    check("R9 burst closed by reset", brk_pulse, 1'b1);

    // R10: config change applies to the strobe in the same cycle
    set_cfg(1'b1, 2'b10, 1'b0, 2'b10, 32'h3000);
    strobe(32'h3000, 2'b10, 1'b0, 1'b0);
    check("R10 old target", brk_pulse, 1'b1);
    cfg_addr = 32'h3004;
    strobe(32'h3000, 2'b10, 1'b0, 1'b0);
    check("R10 old address now misses", brk_pulse, 1'b0);
    strobe(32'h3004, 2'b10, 1'b0, 1'b0);
    check("R10 new target", brk_pulse, 1'b1);
    cfg_en = 1'b0;
    strobe(32'h3004, 2'b10, 1'b0, 1'b0);
    check("R8 enable dropped", brk_pulse, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule